// File: doc/BRIEF.md
# SPI-Mode Memory Card Block Transfer Engine

This engine moves one data block between a host and a memory card whose serial link has already been brought up and whose read or write command has already been sent. The engine starts only after the separate command port has received the card's one-byte R1 answer. It owns the serial clock and the host-to-card data line for the data phase. It exchanges whole bytes in SPI mode 0, most significant bit first.

For a read, it clocks 0xFF and watches the returned bytes. It waits for the 0xFE start token, for an error token, or for the end of a polling budget set by the caller. It then passes the payload out one byte per strobe and checks the two trailing CRC bytes. For a write, it sends the start token and pulls the payload from a byte source. It appends its own CRC16 and decodes the card's data response byte. It then keeps clocking 0xFF while the card holds the line at zero to signal busy. Each job ends with a one-cycle `done` pulse and a three-bit status code.

The controller has twelve states. From `S_IDLE`, `start_rd` goes to `S_RD_POLL` and `start_wr` goes to `S_WR_TOKEN`.

Read path:
- `S_RD_POLL` goes to `S_RD_DATA` on the start token.
- `S_RD_POLL` goes to `S_FINISH` on an error token or when the polling budget runs out.
- `S_RD_DATA` goes to `S_RD_CRC_HI` after the last payload byte.
- `S_RD_CRC_HI` then goes to `S_RD_CRC_LO`, then to `S_FINISH`.

Write path:
- `S_WR_TOKEN` goes to `S_WR_DATA`.
- `S_WR_DATA` goes to `S_WR_CRC_HI` after the last payload byte.
- `S_WR_CRC_HI` then goes to `S_WR_CRC_LO`, then to `S_WR_RESP`, then to `S_WR_BUSY`.
- `S_WR_BUSY` goes to `S_FINISH` on a nonzero byte or when the busy budget runs out.

`S_FINISH` always returns to `S_IDLE` after one cycle.

Top module: `sdx_block_engine`

## Requirements
- R1: While reset is held and after it is released, `sclk` is low, `mosi` is high, and `busy`, `done`, `rd_valid` and `wr_take` are low. Whenever `busy` is low, `sclk` is low and `mosi` is high.
- R2: Every byte is exchanged as eight `sclk` pulses in SPI mode 0, with `mosi` carrying the most significant bit first and `miso` sampled on the rising edge. In every read state the engine transmits 0xFF.
- R3: A read polls until `miso` returns 0xFE. The next N bytes then appear in order on `rd_data`, one per `rd_valid` strobe. N is `blk_len`, or 512 when `high_cap` is set or `blk_len` is 0 or above 512.
- R4: The CRC16 uses the generator x^16+x^12+x^5+1 and starts from 0. It is the remainder of the payload bits times x^16, taken most significant bit first. After a read, a mismatch with the two received CRC bytes (high byte first) gives status 1 and sets `crc_error`. A match gives status 0.
- R5: During polling, any byte other than 0xFF or 0xFE is an error token. The read ends with status 2, that byte on `err_token`, and no `rd_valid` strobe.
- R6: If `rd_limit` polled bytes all return 0xFF, the read ends with status 3 after exactly `rd_limit` bytes. A limit of 0 counts as 1.
- R7: A write sends 0xFE, then N payload bytes, then the CRC16 high byte and low byte. N follows the R3 rule. Each payload byte is taken from `wr_data` in a cycle in which `wr_take` pulses, one pulse per byte.
- R8: The byte after the write CRC is the data response, and its bits [3:1] set the status:
  - 010 gives status 0.
  - 101 gives status 4.
  - 110 gives status 5.
  - Any other value gives status 6.
- R9: After the data response, the engine clocks 0xFF until `miso` returns a nonzero byte and then finishes. If `BUSY_LIMIT` busy bytes all return 0x00, the write ends with status 7.
- R10: `done` is a single-cycle pulse and `busy` is low in the cycle after it. `status`, `crc_error` and `err_token` hold their values until the next start.
- R11: `start_rd` and `start_wr` are ignored while `busy` is high. If both are raised together in `S_IDLE`, the read is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_rd | input | 1 | Begin a block read (sampled in idle) |
| start_wr | input | 1 | Begin a block write (sampled in idle) |
| blk_len | input | LEN_W (10) | Payload length in bytes |
| high_cap | input | 1 | Forces a 512-byte payload |
| rd_limit | input | LIM_W (16) | Polling budget for the start token, in bytes |
| wr_data | input | 8 | Write payload byte, taken when `wr_take` pulses |
| wr_take | output | 1 | Engine consumes `wr_data` this cycle |
| rd_data | output | 8 | Read payload byte |
| rd_valid | output | 1 | `rd_data` holds a payload byte this cycle |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| status | output | 3 | Result code of the last job (codes in R4 to R9) |
| crc_error | output | 1 | Last read failed its CRC check |
| err_token | output | 8 | Error token of the last failed read, else 0 |
| sclk | output | 1 | Serial clock to the card |
| mosi | output | 1 | Host-to-card data |
| miso | input | 1 | Card-to-host data |

## Verification
The bench checks that the start token is found after a varying number of idle bytes. A design that misaligned polling would shift the payload by one byte or drop the first byte.

It checks both ends of the length rule: a one-byte block, a 512-byte block forced by `high_cap`, and a write CRC over 512 bytes of 0xFF that must equal 0x7FA1. A wrong generator or wrong bit order breaks this value. The bench also checks the exact number of bytes clocked on a start-token timeout, including a limit of zero. An off-by-one counter would add or lose one byte there.

It checks every data response code and a busy wait that never ends, so that a decoder using the wrong bit field, or a busy loop without a bound, produces the wrong status. Finally, it raises start pulses during an active read and together at idle. A design that did not block the second start would send a 0xFE in the middle of the read.

// File: rtl/sdx_pkg.sv
package sdx_pkg;

    localparam logic [7:0] START_TOKEN = 8'hFE;
    localparam logic [7:0] IDLE_BYTE   = 8'hFF;

    localparam logic [2:0] RESP_ACCEPT  = 3'b010;
    localparam logic [2:0] RESP_CRC_REJ = 3'b101;
    localparam logic [2:0] RESP_WR_FAIL = 3'b110;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_POLL,
        S_RD_DATA,
        S_RD_CRC_HI,
        S_RD_CRC_LO,
        S_WR_TOKEN,
        S_WR_DATA,
        S_WR_CRC_HI,
        S_WR_CRC_LO,
        S_WR_RESP,
        S_WR_BUSY,
        S_FINISH
    } eng_state_e;

    typedef enum logic [2:0] {
        XS_OK          = 3'd0,
        XS_CRC_BAD     = 3'd1,
        XS_ERR_TOKEN   = 3'd2,
        XS_START_TMO   = 3'd3,
        XS_WR_CRC_REJ  = 3'd4,
        XS_WR_FAIL     = 3'd5,
        XS_WR_BAD_RESP = 3'd6,
        XS_BUSY_TMO    = 3'd7
    } xfer_status_e;

    // Advance a CRC16 register by one byte, most significant bit first.
    function automatic logic [15:0] crc16_step(input logic [15:0] cur,
                                               input logic [7:0]  din,
                                               input logic [15:0] poly);
        logic [15:0] r;
        logic        fb;
        r = cur;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ din[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

endpackage

// File: rtl/sdx_crc16.sv
module sdx_crc16 import sdx_pkg::*; #(
    parameter logic [15:0] POLY = 16'h1021
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc <= '0;
        end else if (clr) begin
            crc <= '0;
        end else if (en) begin
            crc <= crc16_step(crc, din, POLY);
        end
    end

endmodule

// File: rtl/sdx_byte_xchg.sv
module sdx_byte_xchg #(
    parameter int HALF_DIV = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sclk,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);

    localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(HALF_DIV - 1);

    logic             active;
    logic             sclk_q;
    logic [2:0]       bit_q;
    logic [DIV_W-1:0] div_q;
    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;
    logic             done_q;
    logic             tick;

    assign tick = active && (div_q == DIV_TOP);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            active <= 1'b0;
            sclk_q <= 1'b0;
            bit_q  <= '0;
            div_q  <= '0;
            tx_sh  <= '1;
            rx_sh  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!active) begin
                if (go) begin
                    active <= 1'b1;
                    tx_sh  <= tx_byte;
                    bit_q  <= '0;
                    div_q  <= '0;
                    sclk_q <= 1'b0;
                end
            end else if (tick) begin
                div_q <= '0;
                if (!sclk_q) begin
                    sclk_q <= 1'b1;
                    rx_sh  <= {rx_sh[6:0], miso};
                end else begin
                    sclk_q <= 1'b0;
                    if (bit_q == 3'd7) begin
                        active <= 1'b0;
                        done_q <= 1'b1;
                    end else begin
                        bit_q <= bit_q + 3'd1;
                        tx_sh <= {tx_sh[6:0], 1'b1};
                    end
                end
            end else begin
                div_q <= div_q + 1'b1;
            end
        end
    end

    assign sclk    = sclk_q;
    assign mosi    = active ? tx_sh[7] : 1'b1;
    assign rx_byte = rx_sh;
    assign done    = done_q;

endmodule

// File: rtl/sdx_block_engine.sv
module sdx_block_engine import sdx_pkg::*; #(
    parameter int HALF_DIV   = 2,
    parameter int MAX_BLK    = 512,
    parameter int LIM_W      = 16,
    parameter int BUSY_LIMIT = 4096
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start_rd,
    input  logic                             start_wr,
    input  logic [$clog2(MAX_BLK+1)-1:0]     blk_len,
    input  logic                             high_cap,
    input  logic [LIM_W-1:0]                 rd_limit,
    input  logic [7:0]                       wr_data,
    output logic                             wr_take,
    output logic [7:0]                       rd_data,
    output logic                             rd_valid,
    output logic                             busy,
    output logic                             done,
    output logic [2:0]                       status,
    output logic                             crc_error,
    output logic [7:0]                       err_token,
    output logic                             sclk,
    output logic                             mosi,
    input  logic                             miso
);

    localparam int LEN_W = $clog2(MAX_BLK + 1);
    localparam int CNT_W = ((LIM_W > LEN_W) ? LIM_W : LEN_W) + 1;
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(MAX_BLK);

    eng_state_e   st, nxt;
    logic         go;
    logic [7:0]   tx;
    logic         xd;
    logic [7:0]   rx;
    logic         launched;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic [LEN_W-1:0] len_q;
    logic [LIM_W-1:0] lim_q;
    xfer_status_e result_q;
    logic         crc_err_q;
    logic [7:0]   tok_q;
    logic [7:0]   rcv_hi;
    logic         rd_valid_q;
    logic [7:0]   rd_data_q;
    logic [15:0]  crc;
    logic         crc_en;
    logic [7:0]   crc_din;
    logic         last_pay, poll_over, busy_over;
    logic         starting;

    sdx_byte_xchg #(.HALF_DIV(HALF_DIV)) u_xchg (
        .clk     (clk),
        .rst_n   (rst_n),
        .go      (go),
        .tx_byte (tx),
        .miso    (miso),
        .sclk    (sclk),
        .mosi    (mosi),
        .rx_byte (rx),
        .done    (xd)
    );

    assign crc_en  = (go && st == S_WR_DATA) || (xd && st == S_RD_DATA);
    assign crc_din = (st == S_WR_DATA) ? wr_data : rx;

    sdx_crc16 #(.POLY(16'h1021)) u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (st == S_IDLE),
        .en    (crc_en),
        .din   (crc_din),
        .crc   (crc)
    );

    always_comb begin
        cnt_nx    = cnt + 1'b1;
        last_pay  = (cnt_nx == CNT_W'(len_q));
        poll_over = (cnt_nx >= CNT_W'(lim_q));
        busy_over = (cnt_nx >= CNT_W'(BUSY_LIMIT));
        starting  = (st == S_IDLE) && (nxt != S_IDLE);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nxt;
    end

    // Next state, byte launch and transmit byte
    always_comb begin
        nxt = st;
        go  = 1'b0;
        tx  = IDLE_BYTE;
        if (st != S_IDLE && st != S_FINISH && !launched) go = 1'b1;
        unique case (st)
            S_IDLE: begin
                if (start_rd)      nxt = S_RD_POLL;
                else if (start_wr) nxt = S_WR_TOKEN;
            end
            S_RD_POLL: begin
                if (xd) begin
                    if (rx == START_TOKEN)                nxt = S_RD_DATA;
                    else if (rx != IDLE_BYTE || poll_over) nxt = S_FINISH;
                end
            end
            S_RD_DATA:   if (xd && last_pay) nxt = S_RD_CRC_HI;
            S_RD_CRC_HI: if (xd) nxt = S_RD_CRC_LO;
            S_RD_CRC_LO: if (xd) nxt = S_FINISH;
            S_WR_TOKEN: begin
                tx = START_TOKEN;
                if (xd) nxt = S_WR_DATA;
            end
            S_WR_DATA: begin
                tx = wr_data;
                if (xd && last_pay) nxt = S_WR_CRC_HI;
            end
            S_WR_CRC_HI: begin
                tx = crc[15:8];
                if (xd) nxt = S_WR_CRC_LO;
            end
            S_WR_CRC_LO: begin
                tx = crc[7:0];
                if (xd) nxt = S_WR_RESP;
            end
            S_WR_RESP:   if (xd) nxt = S_WR_BUSY;
            S_WR_BUSY:   if (xd && (rx != 8'h00 || busy_over)) nxt = S_FINISH;
            S_FINISH:    nxt = S_IDLE;
            default:     nxt = S_IDLE;
        endcase
    end

    // Datapath and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            launched   <= 1'b0;
            cnt        <= '0;
            len_q      <= FULL_LEN;
            lim_q      <= '0;
            result_q   <= XS_OK;
            crc_err_q  <= 1'b0;
            tok_q      <= '0;
            rcv_hi     <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= xd && (st == S_RD_DATA);
            if (xd) rd_data_q <= rx;

            if (go)      launched <= 1'b1;
            else if (xd) launched <= 1'b0;

            if (st == S_IDLE)  cnt <= '0;
            else if (xd)       cnt <= (nxt != st) ? '0 : cnt_nx;

            if (starting) begin
                len_q     <= (high_cap || blk_len == '0 || blk_len > FULL_LEN) ? FULL_LEN : blk_len;
                lim_q     <= rd_limit;
                result_q  <= XS_OK;
                crc_err_q <= 1'b0;
                tok_q     <= '0;
            end

            if (xd) begin
                case (st)
                    S_RD_POLL: begin
                        if (rx != START_TOKEN && rx != IDLE_BYTE) begin
                            result_q <= XS_ERR_TOKEN;
                            tok_q    <= rx;
                        end else if (rx == IDLE_BYTE && poll_over) begin
                            result_q <= XS_START_TMO;
                        end
                    end
                    S_RD_CRC_HI: rcv_hi <= rx;
                    S_RD_CRC_LO: begin
                        if ({rcv_hi, rx} != crc) begin
                            result_q  <= XS_CRC_BAD;
                            crc_err_q <= 1'b1;
                        end
                    end
                    S_WR_RESP: begin
                        case (rx[3:1])
                            RESP_ACCEPT:  result_q <= XS_OK;
                            RESP_CRC_REJ: result_q <= XS_WR_CRC_REJ;
                            RESP_WR_FAIL: result_q <= XS_WR_FAIL;
                            default:      result_q <= XS_WR_BAD_RESP;
                        endcase
                    end
                    S_WR_BUSY: begin
                        if (rx == 8'h00 && busy_over) result_q <= XS_BUSY_TMO;
                    end
                    default: ;
                endcase
            end
        end
    end

    assign wr_take   = go && (st == S_WR_DATA);
    assign rd_data   = rd_data_q;
    assign rd_valid  = rd_valid_q;
    assign busy      = (st != S_IDLE);
    assign done      = (st == S_FINISH);
    assign status    = result_q;
    assign crc_error = crc_err_q;
    assign err_token = tok_q;

endmodule

// File: rtl/sdx_engine_checks.sv
module sdx_engine_checks (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       sclk,
    input logic       mosi,
    input logic       rd_valid,
    input logic       wr_take,
    input logic [2:0] status,
    input logic       crc_error,
    input logic [7:0] err_token
);

    assert_idle_lines_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk && mosi));

    assert_payload_in_job_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> busy);

    assert_crc_flag_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        crc_error |-> (status == 3'd1));

    assert_take_in_job_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_take |-> (busy && !done));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_idle_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> ($stable(status) && $stable(crc_error) && $stable(err_token)));

    assert_job_not_restarted_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

bind sdx_block_engine sdx_engine_checks u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .sclk      (sclk),
    .mosi      (mosi),
    .rd_valid  (rd_valid),
    .wr_take   (wr_take),
    .status    (status),
    .crc_error (crc_error),
    .err_token (err_token)
);

// File: tb/sim_sdx_block_engine.sv
module sim_sdx_block_engine;

    localparam int BUSY_LIM = 20;
    localparam int ST_OK = 0, ST_CRC_BAD = 1, ST_ERR_TOKEN = 2, ST_START_TMO = 3;
    localparam int ST_WR_CRC_REJ = 4, ST_WR_FAIL = 5, ST_WR_BAD_RESP = 6, ST_BUSY_TMO = 7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n, start_rd, start_wr, high_cap, miso;
    logic [9:0]  blk_len;
    logic [15:0] rd_limit;
    logic [7:0]  wr_data, rd_data, err_token;
    logic        wr_take, rd_valid, busy, done, crc_error, sclk, mosi;
    logic [2:0]  status;

    sdx_block_engine #(.HALF_DIV(2), .MAX_BLK(512), .LIM_W(16), .BUSY_LIMIT(BUSY_LIM)) u0 (
        .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
        .blk_len(blk_len), .high_cap(high_cap), .rd_limit(rd_limit),
        .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
        .busy(busy), .done(done), .status(status), .crc_error(crc_error),
        .err_token(err_token), .sclk(sclk), .mosi(mosi), .miso(miso)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Payload store shared by read model and write source
    logic [7:0] pay [0:511];
    logic [9:0] wr_idx;
    logic       wr_clr = 1'b0;
    assign wr_data = pay[wr_idx[8:0]];
    always @(posedge clk) begin
        if (wr_clr)       wr_idx <= '0;
        else if (wr_take) wr_idx <= wr_idx + 10'd1;
    end

    // Card model: mode 0, MSB first
    logic [7:0] card_q [$];
    logic [7:0] host_bytes [$];
    logic [7:0] in_sh, out_sh;
    int         bits;
    logic       arm = 1'b0;
    assign miso = out_sh[7];

    always @(posedge sclk or posedge arm) begin
        if (arm) begin
            bits = 0;
            host_bytes.delete();
            out_sh = (card_q.size() > 0) ? card_q.pop_front() : 8'hFF;
        end else begin
            in_sh = {in_sh[6:0], mosi};
            bits++;
            if (bits == 8) begin
                bits = 0;
                host_bytes.push_back(in_sh);
                out_sh = (card_q.size() > 0) ? card_q.pop_front() : 8'hFF;
            end else begin
                out_sh = {out_sh[6:0], 1'b1};
            end
        end
    end

    // Scoreboard monitor for read payload
    logic [7:0] exp_q [$];
    int rd_seen;
    always @(negedge clk) begin
        if (rd_valid) begin
            rd_seen++;
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", "unexpected payload byte", rd_data, 0);
            end else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                chk(rd_data == e, "R3", "payload byte", rd_data, e);
            end
        end
    end

    // Reference CRC: divide payload bits followed by 16 zero bits
    function automatic logic [15:0] ref_crc(input int n);
        logic [15:0] r = '0;
        logic        top;
        for (int i = 0; i < n + 2; i++) begin
            for (int b = 7; b >= 0; b--) begin
                logic bitv;
                bitv = (i < n) ? pay[i][b] : 1'b0;
                top  = r[15];
                r    = {r[14:0], bitv};
                if (top) r = r ^ 16'h1021;
            end
        end
        return r;
    endfunction

    task automatic arm_card();
        @(negedge clk);
        arm = 1'b1;
        #1 arm = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic pulse_start(input bit rd, input bit wr);
        @(negedge clk);
        start_rd = rd;
        start_wr = wr;
        @(negedge clk);
        start_rd = 1'b0;
        start_wr = 1'b0;
    endtask

    task automatic all_host_ff(input string req);
        int bad = 0;
        foreach (host_bytes[i]) if (host_bytes[i] != 8'hFF) bad++;
        chk(bad == 0, req, "host bytes not 0xFF during read", bad, 0);
    endtask

    task automatic do_read(input int len_field, input bit hc, input int lim, input int n_eff,
                           input int pre, input logic [7:0] corrupt, input bit mid_wr, input bit both,
                           input int exp_st, input string req);
        logic [15:0] c;
        card_q.delete();
        exp_q.delete();
        rd_seen = 0;
        for (int i = 0; i < pre; i++) card_q.push_back(8'hFF);
        card_q.push_back(8'hFE);
        for (int i = 0; i < n_eff; i++) begin
            card_q.push_back(pay[i]);
            exp_q.push_back(pay[i]);
        end
        c = ref_crc(n_eff);
        card_q.push_back(c[15:8]);
        card_q.push_back(c[7:0] ^ corrupt);
        arm_card();
        blk_len  = 10'(len_field);
        high_cap = hc;
        rd_limit = 16'(lim);
        pulse_start(1'b1, both);
        if (mid_wr) begin
            repeat (150) @(negedge clk);
            pulse_start(1'b0, 1'b1);
        end
        wait_done();
        chk(int'(status) == exp_st, req, "read status", status, exp_st);
        chk(crc_error == (exp_st == ST_CRC_BAD), "R4", "crc_error flag", crc_error, exp_st == ST_CRC_BAD);
        chk(rd_seen == n_eff, req, "payload byte count", rd_seen, n_eff);
        chk(host_bytes.size() == pre + n_eff + 3, "R2", "bytes clocked in read", host_bytes.size(), pre + n_eff + 3);
        all_host_ff("R2");
    endtask

    task automatic do_write(input int len_field, input bit hc, input int n_eff, input logic [7:0] resp,
                            input int zeros, input int exp_st, input int exp_n, input string req);
        logic [15:0] c;
        int bad;
        card_q.delete();
        for (int i = 0; i < n_eff + 3; i++) card_q.push_back(8'hFF);
        card_q.push_back(resp);
        for (int i = 0; i < zeros; i++) card_q.push_back(8'h00);
        card_q.push_back(8'hFF);
        arm_card();
        @(negedge clk) wr_clr = 1'b1;
        @(negedge clk) wr_clr = 1'b0;
        blk_len  = 10'(len_field);
        high_cap = hc;
        pulse_start(1'b0, 1'b1);
        wait_done();
        c = ref_crc(n_eff);
        chk(int'(status) == exp_st, req, "write status", status, exp_st);
        chk(int'(wr_idx) == n_eff, "R7", "wr_take pulses", wr_idx, n_eff);
        chk(host_bytes.size() == exp_n, req, "bytes clocked in write", host_bytes.size(), exp_n);
        if (host_bytes.size() >= n_eff + 3) begin
            chk(host_bytes[0] == 8'hFE, "R7", "start token", host_bytes[0], 8'hFE);
            bad = 0;
            for (int i = 0; i < n_eff; i++) if (host_bytes[i+1] != pay[i]) bad++;
            chk(bad == 0, "R7", "payload mismatches", bad, 0);
            chk({host_bytes[n_eff+1], host_bytes[n_eff+2]} == c, "R4", "write CRC",
                {host_bytes[n_eff+1], host_bytes[n_eff+2]}, c);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start_rd = 1'b0; start_wr = 1'b0; high_cap = 1'b0;
        blk_len = 10'd8; rd_limit = 16'd100;
        out_sh = 8'hFF; in_sh = 8'hFF; bits = 0; rd_seen = 0;
        wr_clr = 1'b1;
        repeat (3) @(negedge clk);
        chk(!sclk && mosi, "R1", "lines in reset", {sclk, mosi}, 1);
        chk(!busy && !done && !rd_valid && !wr_take, "R1", "controls in reset",
            {busy, done, rd_valid, wr_take}, 0);
        rst_n = 1'b1;
        wr_clr = 1'b0;
        @(negedge clk);
        chk(!sclk && mosi && !busy && !done, "R1", "after reset", {sclk, mosi, busy, done}, 4'b0100);

        // Read, 8 bytes, three idle bytes first
        for (int i = 0; i < 512; i++) pay[i] = 8'(i * 7 + 3);
        do_read(8, 0, 100, 8, 3, 8'h00, 0, 0, ST_OK, "R3");
        // High capacity forces 512
        for (int i = 0; i < 512; i++) pay[i] = 8'(i ^ (i >> 3));
        do_read(8, 1, 100, 512, 0, 8'h00, 0, 0, ST_OK, "R3");
        // One-byte block
        do_read(1, 0, 100, 1, 1, 8'h00, 0, 0, ST_OK, "R3");
        // CRC mismatch
        do_read(4, 0, 100, 4, 2, 8'h40, 0, 0, ST_CRC_BAD, "R4");
        // R10: result holds while idle
        repeat (10) @(negedge clk);
        chk(status == 3'd1 && crc_error && !busy, "R10", "result hold", {status, crc_error}, 4'b0011);

        // R5: error token
        card_q.delete(); exp_q.delete(); rd_seen = 0;
        card_q.push_back(8'hFF); card_q.push_back(8'hFF); card_q.push_back(8'h08);
        arm_card();
        blk_len = 10'd8; high_cap = 1'b0; rd_limit = 16'd100;
        pulse_start(1'b1, 1'b0);
        wait_done();
        chk(status == 3'(ST_ERR_TOKEN), "R5", "error token status", status, ST_ERR_TOKEN);
        chk(err_token == 8'h08, "R5", "error token value", err_token, 8'h08);
        chk(rd_seen == 0, "R5", "payload strobes", rd_seen, 0);
        chk(host_bytes.size() == 3, "R5", "bytes clocked", host_bytes.size(), 3);

        // R6: start token timeout, limit 5 and limit 0
        card_q.delete();
        arm_card();
        rd_limit = 16'd5;
        pulse_start(1'b1, 1'b0);
        wait_done();
        chk(status == 3'(ST_START_TMO), "R6", "timeout status", status, ST_START_TMO);
        chk(host_bytes.size() == 5, "R6", "polled bytes limit 5", host_bytes.size(), 5);
        arm_card();
        rd_limit = 16'd0;
        pulse_start(1'b1, 1'b0);
        wait_done();
        chk(status == 3'(ST_START_TMO), "R6", "timeout status limit 0", status, ST_START_TMO);
        chk(host_bytes.size() == 1, "R6", "polled bytes limit 0", host_bytes.size(), 1);

        // R11: write start during read, then both starts together
        for (int i = 0; i < 512; i++) pay[i] = 8'(255 - i);
        do_read(16, 0, 100, 16, 2, 8'h00, 1, 0, ST_OK, "R11");
        do_read(6, 0, 100, 6, 1, 8'h00, 0, 1, ST_OK, "R11");

        // Writes
        for (int i = 0; i < 512; i++) pay[i] = 8'(i * 13 + 1);
        do_write(6, 0, 6, 8'hE5, 3, ST_OK, 6 + 4 + 4, "R9");
        for (int i = 0; i < 512; i++) pay[i] = 8'hFF;
        do_write(8, 1, 512, 8'hE5, 0, ST_OK, 512 + 4 + 1, "R7");
        chk({host_bytes[513], host_bytes[514]} == 16'h7FA1, "R4", "CRC of 512 x 0xFF",
            {host_bytes[513], host_bytes[514]}, 16'h7FA1);
        for (int i = 0; i < 512; i++) pay[i] = 8'(i + 40);
        do_write(5, 0, 5, 8'h0B, 2, ST_WR_CRC_REJ, 5 + 4 + 3, "R8");
        do_write(5, 0, 5, 8'h0D, 0, ST_WR_FAIL, 5 + 4 + 1, "R8");
        do_write(5, 0, 5, 8'h07, 0, ST_WR_BAD_RESP, 5 + 4 + 1, "R8");
        do_write(3, 0, 3, 8'hE5, 30, ST_BUSY_TMO, 3 + 4 + BUSY_LIM, "R9");

        @(negedge clk);
        chk(!busy && !sclk && mosi, "R10", "idle after last job", {busy, sclk, mosi}, 3'b001);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule